// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block serves one group of sixteen lane requests against a scratchpad split into sixteen single-port word banks. Each lane carries an active flag and a word address. The whole group is either a load or a store, and for a store each lane also carries write data. The bank for a lane is taken from the low address bits. Lanes that land in different banks are served together in one cycle. Lanes that need different words of the same bank are replayed over later cycles. Lanes that need the same word share one bank access: a load broadcasts the word to all of them, and a store keeps the data of the highest-numbered lane.

In each service cycle, every bank takes its lowest-numbered pending lane as the leader. That lane and every other pending lane that names the same word are retired together. The number of service cycles for a group therefore equals the largest count of distinct words requested from any single bank. When the group is finished, the block pulses a done flag, holds the read data for each lane, and reports the number of service cycles the group used. The request port is not ready while a group is in flight.

Top module: `bank_conflict_serializer`

## Requirements
- R1: A word address selects bank = address[3:0] and row = address[7:4]. A word stored at any address is returned by a later load of that address, whatever other rows of the same bank hold.
- R2: `req_ready` is high only when no group is in flight. It drops on the cycle after a group is accepted and rises with the done pulse. A request presented while `req_ready` is low is not taken and does not change the storage.
- R3: If every active lane maps to a different bank, the group uses one service cycle (`svc_cycles` = 1), and `rsp_done` is visible after the second clock edge following the accepting edge.
- R4: If all sixteen lanes load the same word, the group uses one service cycle and every lane returns that word.
- R5: For any other group, `svc_cycles` equals the largest number of distinct words requested from one bank, and `rsp_done` is visible after edge 1 + `svc_cycles` counted from the accepting edge. Stores follow the same count.
- R6: For a full group with addresses base + stride × lane: an odd stride gives 1 service cycle, stride 2 gives 2, stride 4 gives 4, stride 8 gives 8 and stride 16 gives 16.
- R7: When several lanes of one store group write the same word, the data of the highest-numbered of those lanes is the value that remains.
- R8: Inactive lanes are not served. Their `rsp_rdata` slots keep their previous values. A group with no active lane reports `svc_cycles` = 0, and its `rsp_done` is visible after the second edge following acceptance.
- R9: `rsp_done` is high for exactly one cycle per group. `svc_cycles` holds the count of the last finished group until the next one finishes.
- R10: After reset, `req_ready` = 1, `rsp_done` = 0, `svc_cycles` = 0 and every `rsp_rdata` lane is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request group is presented |
| req_ready | output | 1 | The block can accept a group this cycle |
| req_store | input | 1 | 1 = store group, 0 = load group |
| req_active | input | 16 | Per-lane active flags, bit n = lane n |
| req_addr | input | 128 | Word addresses, lane n at bits [8n+7:8n] |
| req_wdata | input | 512 | Store data, lane n at bits [32n+31:32n] |
| rsp_done | output | 1 | One-cycle pulse when a group is finished |
| rsp_rdata | output | 512 | Load data per lane, lane n at bits [32n+31:32n] |
| svc_cycles | output | 5 | Service cycles used by the last finished group |

## Verification
The main function is driven with strided full groups (strides 1, 3, 2, 4, 8, 16 and 0) and with a half-active group. These separate conflict-free service, 2-, 4-, 8- and 16-way serialization, and same-word broadcast. A mixed group, in which one bank sees a repeated word among three distinct words while the other lanes spread across the remaining banks, tells merging apart from counting and exercises the highest-lane-wins store. Each group is checked for its cycle count, its done latency and, for loads, its per-lane data against a memory model kept in the bench. Single-lane, empty and busy-time requests confirm that untouched lanes and refused requests leave no trace.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SERVE = 2'd1,
    ST_DRAIN = 2'd2
  } ssm_state_e;
endpackage

// File: rtl/ssm_bank_ram.sv
module ssm_bank_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int RW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wd;
      rd <= mem[row];
    end
  end
endmodule

// File: rtl/ssm_picker.sv
module ssm_picker #(
  parameter int LANES = 16,
  parameter int BANKS = 16,
  parameter int AW    = 8,
  parameter int DW    = 32,
  localparam int BW   = $clog2(BANKS),
  localparam int RW   = AW - BW
) (
  input  logic [LANES-1:0]    pend,
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES*DW-1:0] wdata,
  output logic [BANKS-1:0]    bank_en,
  output logic [BANKS*RW-1:0] bank_row,
  output logic [BANKS*DW-1:0] bank_wd,
  output logic [LANES-1:0]    served
);
  logic [AW-1:0] lead [BANKS];

  // Leader per bank: lowest pending lane (descending scan, last hit wins).
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      lead[b]    = '0;
      bank_en[b] = 1'b0;
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pend[l] && addr[l*AW +: BW] == BW'(b)) begin
          lead[b]    = addr[l*AW +: AW];
          bank_en[b] = 1'b1;
        end
      end
    end
  end

  // A lane retires when it names the same word as its bank's leader.
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      served[l] = pend[l] && (addr[l*AW +: AW] == lead[addr[l*AW +: BW]]);
    end
  end

  // Row from the leader; store data from the highest retiring lane.
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      bank_row[b*RW +: RW] = lead[b][AW-1:BW];
      bank_wd[b*DW +: DW]  = '0;
      for (int l = 0; l < LANES; l++) begin
        if (served[l] && addr[l*AW +: BW] == BW'(b))
          bank_wd[b*DW +: DW] = wdata[l*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/bank_conflict_serializer.sv
module bank_conflict_serializer #(
  parameter int LANES  = 16,
  parameter int BANKS  = 16,
  parameter int AW     = 8,
  parameter int DW     = 32,
  localparam int BW    = $clog2(BANKS),
  localparam int RW    = AW - BW,
  localparam int DEPTH = 1 << RW,
  localparam int CW    = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_store,
  input  logic [LANES-1:0]    req_active,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES*DW-1:0] req_wdata,
  output logic                rsp_done,
  output logic [LANES*DW-1:0] rsp_rdata,
  output logic [CW-1:0]       svc_cycles
);
  import ssm_pkg::*;

  ssm_state_e          state_q;
  logic [LANES-1:0]    pend_q;
  logic [LANES-1:0]    cap_q;
  logic                store_q;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES*DW-1:0] wdata_q;
  logic [CW-1:0]       cnt_q;
  logic                done_q;
  logic [CW-1:0]       cyc_q;
  logic [LANES*DW-1:0] rdata_q;

  logic [BANKS-1:0]    pick_en;
  logic [BANKS*RW-1:0] pick_row;
  logic [BANKS*DW-1:0] pick_wd;
  logic [LANES-1:0]    served;
  logic [BANKS*DW-1:0] bank_rd;
  logic                serving;
  logic [LANES-1:0]    pend_next;

  assign serving   = (state_q == ST_SERVE);
  assign pend_next = pend_q & ~served;

  ssm_picker #(.LANES(LANES), .BANKS(BANKS), .AW(AW), .DW(DW)) u_picker (
    .pend     (pend_q),
    .addr     (addr_q),
    .wdata    (wdata_q),
    .bank_en  (pick_en),
    .bank_row (pick_row),
    .bank_wd  (pick_wd),
    .served   (served)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    ssm_bank_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
      .clk (clk),
      .en  (serving && pick_en[b]),
      .we  (store_q),
      .row (pick_row[b*RW +: RW]),
      .wd  (pick_wd[b*DW +: DW]),
      .rd  (bank_rd[b*DW +: DW])
    );
  end

  // Request latch; plain registers with no reset.
  always_ff @(posedge clk) begin
    if (state_q == ST_IDLE && req_valid) begin
      store_q <= req_store;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // Sequencer.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      cyc_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            pend_q  <= req_active;
            cnt_q   <= '0;
            state_q <= ST_SERVE;
          end
        end
        ST_SERVE: begin
          pend_q <= pend_next;
          if (pend_q != '0) cnt_q <= cnt_q + CW'(1);
          if (pend_next == '0) state_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          done_q  <= 1'b1;
          cyc_q   <= cnt_q;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Read capture one cycle after the bank access.
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q   <= '0;
      rdata_q <= '0;
    end else begin
      cap_q <= (serving && !store_q) ? served : '0;
      for (int l = 0; l < LANES; l++) begin
        if (cap_q[l])
          rdata_q[l*DW +: DW] <= bank_rd[addr_q[l*AW +: BW]*DW +: DW];
      end
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign rsp_done   = done_q;
  assign rsp_rdata  = rdata_q;
  assign svc_cycles = cyc_q;
endmodule

// File: rtl/ssm_checker.sv
module ssm_checker #(
  parameter int LANES = 16,
  localparam int CW   = $clog2(LANES + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_done,
  input logic [CW-1:0]    svc_cycles,
  input logic [LANES-1:0] pend
);
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);  // R2
  AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> req_ready);  // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);  // R9
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> $past(!req_ready));  // R3
  AST_CYCLES_BOUND: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> svc_cycles <= CW'(LANES));  // R5
  AST_PEND_SHRINK: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> (pend & ~$past(pend)) == '0);  // R5
endmodule

bind bank_conflict_serializer ssm_checker #(.LANES(LANES)) u_checker (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_done   (rsp_done),
  .svc_cycles (svc_cycles),
  .pend       (pend_q)
);

// File: tb/bank_conflict_serializer_bench.sv
module bank_conflict_serializer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16;
  localparam int AW    = 8;
  localparam int DW    = 32;

  typedef struct packed {
    logic [7:0]  base;
    logic [7:0]  stride;
    logic [15:0] mask;
    logic [4:0]  exp;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t TABLE [NVEC] = '{
    '{8'h00, 8'd1,  16'hFFFF, 5'd1},   // R3 R6 stride 1
    '{8'h21, 8'd3,  16'hFFFF, 5'd1},   // R6 odd stride
    '{8'h40, 8'd2,  16'hFFFF, 5'd2},   // R6 stride 2
    '{8'h80, 8'd8,  16'hFFFF, 5'd8},   // R6 stride 8
    '{8'h05, 8'd16, 16'hFFFF, 5'd16},  // R1 R6 stride 16
    '{8'h30, 8'd4,  16'hFFFF, 5'd4},   // R6 stride 4
    '{8'h77, 8'd0,  16'hFFFF, 5'd1},   // R4 R7 same word
    '{8'h90, 8'd2,  16'h00FF, 5'd1}    // R3 half active
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_store = 1'b0;
  logic [LANES-1:0] req_active = '0;
  logic [LANES-1:0][AW-1:0] req_addr = '0;
  logic [LANES-1:0][DW-1:0] req_wdata = '0;
  logic rsp_done;
  logic [LANES*DW-1:0] rsp_rdata;
  logic [4:0] svc_cycles;

  int nchk = 0;
  int nerr = 0;
  logic [DW-1:0] model [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_conflict_serializer u_bank_conflict_serializer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_active(req_active), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .svc_cycles(svc_cycles)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] lane_rd(input int l);
    return rsp_rdata[l*DW +: DW];
  endfunction

  // Presents one group, waits for done, returns edges from acceptance to done.
  task automatic run_group(input bit st, input logic [15:0] act,
                           input logic [15:0][7:0] ad, input logic [15:0][31:0] wd,
                           output int lat);
    @(negedge clk);
    req_store = st; req_active = act; req_addr = ad; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    if (st) begin
      for (int l = 0; l < LANES; l++) if (act[l]) model[ad[l]] = wd[l];
    end
  endtask

  task automatic check_done_drop(input string tag);
    @(negedge clk);
    chk(rsp_done == 1'b0, tag, 32'(rsp_done), 32'd0);
  endtask

  task automatic check_loads(input logic [15:0] act, input logic [15:0][7:0] ad, input string tag);
    for (int l = 0; l < LANES; l++)
      if (act[l]) chk(lane_rd(l) == model[ad[l]], tag, lane_rd(l), model[ad[l]]);
  endtask

  function automatic logic [15:0][7:0] strided(input logic [7:0] base, input logic [7:0] stride);
    logic [15:0][7:0] a;
    for (int l = 0; l < LANES; l++) a[l] = 8'(base + stride * l);
    return a;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int lat;
    logic [15:0][7:0]  ad;
    logic [15:0][31:0] wd;
    logic [LANES*DW-1:0] snap;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b1, "R10 ready", 32'(req_ready), 32'd1);
    chk(rsp_done == 1'b0, "R10 done", 32'(rsp_done), 32'd0);
    chk(svc_cycles == 5'd0, "R10 cycles", 32'(svc_cycles), 32'd0);
    chk(rsp_rdata == '0, "R10 rdata", rsp_rdata[31:0], 32'd0);

    // Table walk: store then load of each strided pattern.
    for (int e = 0; e < NVEC; e++) begin
      ad = strided(TABLE[e].base, TABLE[e].stride);
      for (int l = 0; l < LANES; l++) wd[l] = {8'(e), 8'(l), 16'hBE5A};
      run_group(1'b1, TABLE[e].mask, ad, wd, lat);
      chk(svc_cycles == TABLE[e].exp, "R5 R6 store cycles", 32'(svc_cycles), 32'(TABLE[e].exp));
      chk(lat == int'(TABLE[e].exp) + 1, "R3 R5 store latency", 32'(lat), 32'(TABLE[e].exp) + 1);
      run_group(1'b0, TABLE[e].mask, ad, wd, lat);
      chk(svc_cycles == TABLE[e].exp, "R5 R6 load cycles", 32'(svc_cycles), 32'(TABLE[e].exp));
      chk(lat == int'(TABLE[e].exp) + 1, "R3 R5 load latency", 32'(lat), 32'(TABLE[e].exp) + 1);
      check_loads(TABLE[e].mask, ad, "R1 R4 load data");
      check_done_drop("R9 done pulse");
    end
    // R7: same-word store kept lane 15's data
    chk(model[8'h77] == {8'd6, 8'd15, 16'hBE5A}, "R7 model", model[8'h77], {8'd6, 8'd15, 16'hBE5A});
    ad = strided(8'h77, 8'd0);
    run_group(1'b0, 16'h0001, ad, wd, lat);
    chk(lane_rd(0) == {8'd6, 8'd15, 16'hBE5A}, "R7 highest lane wins", lane_rd(0), {8'd6, 8'd15, 16'hBE5A});

    // Mixed group: bank 3 sees 0x03, 0x13, 0x03, 0x23 -> 3 cycles.
    ad = strided(8'h40, 8'd1);
    ad[0] = 8'h03; ad[1] = 8'h13; ad[2] = 8'h03; ad[3] = 8'h23;
    for (int l = 0; l < LANES; l++) wd[l] = 32'hC0DE_0000 + 32'(l);
    run_group(1'b1, 16'hFFFF, ad, wd, lat);
    chk(svc_cycles == 5'd3, "R5 mixed store cycles", 32'(svc_cycles), 32'd3);
    run_group(1'b0, 16'hFFFF, ad, wd, lat);
    chk(svc_cycles == 5'd3, "R5 mixed load cycles", 32'(svc_cycles), 32'd3);
    chk(lat == 4, "R5 mixed latency", 32'(lat), 32'd4);
    chk(lane_rd(0) == 32'hC0DE_0002, "R7 mixed duplicate store", lane_rd(0), 32'hC0DE_0002);
    check_loads(16'hFFFF, ad, "R1 mixed data");

    // R8: single active lane leaves other lanes untouched.
    snap = rsp_rdata;
    ad = strided(8'h00, 8'd1);
    run_group(1'b0, 16'h0002, ad, wd, lat);
    chk(lane_rd(1) == model[8'h01], "R8 active lane", lane_rd(1), model[8'h01]);
    chk(rsp_rdata[0 +: DW] == snap[0 +: DW], "R8 lane0 held", lane_rd(0), snap[31:0]);
    chk(rsp_rdata[LANES*DW-1:2*DW] == snap[LANES*DW-1:2*DW], "R8 upper lanes held",
        rsp_rdata[2*DW +: DW], snap[2*DW +: DW]);
    chk(svc_cycles == 5'd1, "R8 single lane cycles", 32'(svc_cycles), 32'd1);

    // R8: empty group.
    snap = rsp_rdata;
    run_group(1'b0, 16'h0000, ad, wd, lat);
    chk(svc_cycles == 5'd0, "R8 empty cycles", 32'(svc_cycles), 32'd0);
    chk(lat == 2, "R8 empty latency", 32'(lat), 32'd2);
    chk(rsp_rdata == snap, "R8 empty keeps data", rsp_rdata[31:0], snap[31:0]);

    // R2: request while busy is refused.
    ad = strided(8'h3B, 8'd0);
    wd = '0; wd[0] = 32'h1234_5678;
    run_group(1'b1, 16'h0001, ad, wd, lat);
    @(negedge clk);
    req_store = 1'b1; req_active = 16'hFFFF; req_addr = strided(8'h0A, 8'd16);
    for (int l = 0; l < LANES; l++) req_wdata[l] = 32'h5000_0000 + 32'(l);
    req_valid = 1'b1;
    @(negedge clk);
    for (int l = 0; l < LANES; l++) model[8'(8'h0A + 16 * l)] = 32'h5000_0000 + 32'(l);
    req_addr = strided(8'h3B, 8'd0);
    for (int l = 0; l < LANES; l++) req_wdata[l] = 32'hDEAD_0000 + 32'(l);
    for (int k = 0; k < 3; k++) begin
      chk(req_ready == 1'b0, "R2 not ready while busy", 32'(req_ready), 32'd0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (!rsp_done) @(negedge clk);
    chk(svc_cycles == 5'd16, "R2 busy group cycles", 32'(svc_cycles), 32'd16);
    chk(req_ready == 1'b1, "R2 ready with done", 32'(req_ready), 32'd1);
    ad = strided(8'h3B, 8'd0);
    run_group(1'b0, 16'h0001, ad, wd, lat);
    chk(lane_rd(0) == 32'h1234_5678, "R2 refused store ignored", lane_rd(0), 32'h1234_5678);
    ad = strided(8'h0A, 8'd16);
    run_group(1'b0, 16'hFFFF, ad, wd, lat);
    check_loads(16'hFFFF, ad, "R1 busy group data");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule